// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is one self-contained down-counting timer channel. A decoded control write selects one of six counting behaviours and a count format, which is either 16-bit binary or four-decade BCD. A separate count write stores a new starting value. The channel advances only on clock cycles where the counter-clock enable is high. A gate input pauses counting in some behaviours and acts as a trigger in others. The channel drives a single waveform output, shows the live count, and raises a flag while a written count has not yet reached the counting element.

The six behaviours cover different uses:
- a terminal-count event;
- a retriggerable one-shot;
- a periodic rate pulse;
- a square wave;
- a strobe started by software;
- a strobe started by hardware.

Each behaviour has its own rule for when a freshly written count is taken up. A count of zero stands for the full range: 65536 in binary, 10000 in BCD.

All pins are plain control and status signals, with no stream interface and no back-pressure. A control or count write is a one-cycle strobe. The host never waits on the block.

Top module: `pit_channel`

## Requirements
- R1: After reset, `out_o` is 0, `count_o` is 0 and `null_o` is 1.
- R2: In binary format (`ctl_bcd`=0), a written count of 0 counts 65536 enabled cycles; in mode 0 that places the rising edge of `out_o` 65537 cycles after the count write.
- R3: With `ctl_bcd`=1, the count is four BCD digits (bits 3:0 are the units digit) and decrements with decimal borrow; a count of 0 gives 10000 cycles.
- R4: Mode 0 (`ctl_mode`=0): a count write drives `out_o` low, and `out_o` rises N+1 enabled cycles after the write and stays high; a count written mid-countdown restarts the countdown from the new value.
- R5: Mode 1: a rising edge on `gate` loads the count and drives `out_o` low for exactly N enabled cycles; a count written meanwhile does not change the running shot, and a later trigger restarts with the newest count.
- R6: Mode 2: `out_o` is low for one cycle out of every N (N at least 2); the first low pulse comes N cycles after the count write, and a count written mid-period takes effect only when that period ends.
- R7: Mode 3: a square wave of period N, counting down by two. It is high for ceil(N/2) cycles and low for floor(N/2), and starts high. A count written mid-period applies from the next high half-cycle.
- R8: Mode 4: `out_o` stays high, falls N+1 cycles after the count write for exactly one cycle, then stays high; a new write restarts the count on the next enabled cycle.
- R9: Mode 5: a rising edge on `gate` (re)starts the count; `out_o` falls N+1 cycles after the edge for exactly one cycle.
- R10: A low `gate` pauses counting in modes 0, 2, 3 and 4, and holds `out_o` high in modes 2 and 3.
- R11: `null_o` is set by a count write or a control write, and clears when the written count is transferred into the counting element.
- R12: The count and `out_o` change only in cycles with `cnt_en` high. A control or count write takes the whole cycle, so the count does not advance in that cycle.
- R13: Mode codes 6 and 7 behave exactly as modes 2 and 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Counter-clock enable; one count step per high cycle |
| gate | input | 1 | Gate level; trigger on rising edge in modes 1 and 5 |
| ctl_wr | input | 1 | Control write strobe |
| ctl_mode | input | 3 | Counting mode 0..7 |
| ctl_bcd | input | 1 | 1 selects BCD counting, 0 binary |
| ld_wr | input | 1 | Count write strobe |
| ld_val | input | 16 | Count value to write |
| out_o | output | 1 | Channel waveform output |
| count_o | output | 16 | Current value of the counting element |
| null_o | output | 1 | Written count not yet transferred |

## Verification
The bench sweeps the count value over small ranges in every mode and compares each measured high and low run length with closed-form values. Odd and even counts in mode 3 show whether the asymmetric half-cycle rule is correct. The full-range counts of 0, in both binary and BCD, show whether zero is treated as the maximum and whether decimal borrow is applied. Writes placed partway through a period, retriggers, gate-low pauses and an alternating `cnt_en` pattern show whether each mode takes up a new count and counts enabled cycles correctly.

// File: rtl/pit_pkg.sv
package pit_pkg;

  typedef enum logic [2:0] {
    M_TC      = 3'd0,
    M_ONESHOT = 3'd1,
    M_RATE    = 3'd2,
    M_SQUARE  = 3'd3,
    M_SWSTB   = 3'd4,
    M_HWSTB   = 3'd5
  } pit_mode_e;

  // codes 6 and 7 fold onto the rate and square behaviours
  function automatic pit_mode_e norm_mode(input logic [2:0] m);
    if (m[2:1] == 2'b11) return pit_mode_e'({1'b0, m[1:0]});
    return pit_mode_e'(m);
  endfunction

endpackage

// File: rtl/pit_gate_edge.sv
module pit_gate_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic gate,
  output logic rise
);

  logic gate_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gate_q <= 1'b0;
    else if (en) gate_q <= gate;
  end

  assign rise = en & gate & ~gate_q;

endmodule

// File: rtl/pit_step.sv
module pit_step #(
  parameter int DIGITS = 4,
  parameter bit BCD_EN = 1'b1
) (
  input  logic [4*DIGITS-1:0] cnt,
  input  logic [4*DIGITS-1:0] hi_src,
  input  logic [4*DIGITS-1:0] lo_src,
  input  logic                bcd,
  output logic [4*DIGITS-1:0] dec1,
  output logic [4*DIGITS-1:0] dec2,
  output logic [4*DIGITS-1:0] hi_val,
  output logic [4*DIGITS-1:0] lo_val
);

  localparam int W = 4 * DIGITS;

  function automatic logic [W-1:0] bcd_dec(input logic [W-1:0] v);
    logic [W-1:0] r;
    logic         brw;
    r   = v;
    brw = 1'b1;
    for (int i = 0; i < DIGITS; i++) begin
      if (brw) begin
        if (v[4*i +: 4] == 4'd0) r[4*i +: 4] = 4'd9;
        else begin
          r[4*i +: 4] = v[4*i +: 4] - 4'd1;
          brw = 1'b0;
        end
      end
    end
    return r;
  endfunction

  function automatic logic [W-1:0] bcd_inc(input logic [W-1:0] v);
    logic [W-1:0] r;
    logic         cy;
    r  = v;
    cy = 1'b1;
    for (int i = 0; i < DIGITS; i++) begin
      if (cy) begin
        if (v[4*i +: 4] >= 4'd9) r[4*i +: 4] = 4'd0;
        else begin
          r[4*i +: 4] = v[4*i +: 4] + 4'd1;
          cy = 1'b0;
        end
      end
    end
    return r;
  endfunction

  // low half-cycle reload is always the even part of the period
  assign lo_val = lo_src & ~W'(1);

  if (BCD_EN) begin : g_bcd
    always_comb begin
      if (bcd) begin
        dec1   = bcd_dec(cnt);
        dec2   = bcd_dec(bcd_dec(cnt));
        hi_val = hi_src[0] ? bcd_inc(hi_src) : hi_src;
      end else begin
        dec1   = cnt - W'(1);
        dec2   = cnt - W'(2);
        hi_val = hi_src[0] ? hi_src + W'(1) : hi_src;
      end
    end
  end else begin : g_bin
    always_comb begin
      dec1   = cnt - W'(1);
      dec2   = cnt - W'(2);
      hi_val = hi_src[0] ? hi_src + W'(1) : hi_src;
    end
  end

endmodule

// File: rtl/pit_ctrl.sv
module pit_ctrl
  import pit_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         gate,
  input  logic         trig,
  input  logic         mode_wr,
  input  logic [2:0]   mode_in,
  input  logic         bcd_in,
  input  logic         cnt_wr,
  input  logic [W-1:0] cnt_in,
  input  logic [W-1:0] dec1,
  input  logic [W-1:0] dec2,
  input  logic [W-1:0] hi_val,
  input  logic [W-1:0] lo_val,
  output logic [W-1:0] ce_q,
  output logic [W-1:0] cr_q,
  output logic [W-1:0] per_q,
  output logic         bcd_q,
  output logic         out_q,
  output logic         null_q
);

  pit_mode_e mode_q;
  pit_mode_e mode_nx;
  logic      pend_q;
  logic      run_q;

  assign mode_nx = norm_mode(mode_in);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= M_TC;
      bcd_q  <= 1'b0;
      cr_q   <= '0;
      per_q  <= '0;
      ce_q   <= '0;
      out_q  <= 1'b0;
      null_q <= 1'b1;
      pend_q <= 1'b0;
      run_q  <= 1'b0;
    end else if (mode_wr) begin
      mode_q <= mode_nx;
      bcd_q  <= bcd_in;
      out_q  <= (mode_nx != M_TC);
      null_q <= 1'b1;
      pend_q <= 1'b0;
      run_q  <= 1'b0;
    end else if (cnt_wr) begin
      cr_q   <= cnt_in;
      null_q <= 1'b1;
      pend_q <= 1'b1;
      if (mode_q == M_TC) begin
        out_q <= 1'b0;
        run_q <= 1'b0;
      end
    end else if (tick) begin
      case (mode_q)
        M_TC: begin
          if (pend_q) begin
            ce_q <= cr_q; null_q <= 1'b0; pend_q <= 1'b0; run_q <= 1'b1;
          end else if (run_q && gate) begin
            ce_q <= dec1;
            if (dec1 == '0) out_q <= 1'b1;
          end
        end
        M_ONESHOT: begin
          if (trig) begin
            ce_q <= cr_q; null_q <= 1'b0; pend_q <= 1'b0; run_q <= 1'b1;
            out_q <= 1'b0;
          end else if (run_q) begin
            ce_q <= dec1;
            if (dec1 == '0) begin out_q <= 1'b1; run_q <= 1'b0; end
          end
        end
        M_RATE: begin
          if (!gate) out_q <= 1'b1;
          else if (pend_q && !run_q) begin
            ce_q <= cr_q; null_q <= 1'b0; pend_q <= 1'b0; run_q <= 1'b1;
            out_q <= 1'b1;
          end else if (run_q) begin
            if (ce_q == W'(1)) begin
              ce_q <= cr_q; null_q <= 1'b0; pend_q <= 1'b0; out_q <= 1'b1;
            end else begin
              ce_q  <= dec1;
              out_q <= (dec1 != W'(1));
            end
          end
        end
        M_SQUARE: begin
          if (!gate) out_q <= 1'b1;
          else if (pend_q && !run_q) begin
            ce_q <= hi_val; per_q <= cr_q; null_q <= 1'b0; pend_q <= 1'b0;
            run_q <= 1'b1; out_q <= 1'b1;
          end else if (run_q) begin
            if (dec2 == '0) begin
              if (out_q) ce_q <= lo_val;
              else begin
                ce_q <= hi_val; per_q <= cr_q; null_q <= 1'b0; pend_q <= 1'b0;
              end
              out_q <= ~out_q;
            end else begin
              ce_q <= dec2;
            end
          end
        end
        M_SWSTB: begin
          if (pend_q) begin
            ce_q <= cr_q; null_q <= 1'b0; pend_q <= 1'b0; run_q <= 1'b1;
            out_q <= 1'b1;
          end else if (!out_q) out_q <= 1'b1;
          else if (run_q && gate) begin
            ce_q <= dec1;
            if (dec1 == '0) begin out_q <= 1'b0; run_q <= 1'b0; end
          end
        end
        M_HWSTB: begin
          if (trig) begin
            ce_q <= cr_q; null_q <= 1'b0; pend_q <= 1'b0; run_q <= 1'b1;
            out_q <= 1'b1;
          end else if (!out_q) out_q <= 1'b1;
          else if (run_q) begin
            ce_q <= dec1;
            if (dec1 == '0) begin out_q <= 1'b0; run_q <= 1'b0; end
          end
        end
        default: ;
      endcase
    end
  end

  // R11: a count write always leaves the flag set
  p_null_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr && !mode_wr |=> null_q);

  // R4: terminal-count mode output drops on a count write
  p_tc_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr && !mode_wr && mode_q == M_TC |=> !out_q);

  // R8, R9: strobe low lasts one enabled cycle
  p_strobe_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !mode_wr && !cnt_wr && !out_q &&
    (mode_q == M_SWSTB || mode_q == M_HWSTB) |=> out_q);

  // R10: low gate forces output high in rate and square modes
  p_gate_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !mode_wr && !cnt_wr && !gate &&
    (mode_q == M_RATE || mode_q == M_SQUARE) |=> out_q);

  // R10: low gate freezes a running count
  p_gate_pause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !mode_wr && !cnt_wr && !gate && run_q && !pend_q &&
    (mode_q == M_TC || mode_q == M_RATE || mode_q == M_SQUARE ||
     mode_q == M_SWSTB) |=> $stable(ce_q));

  // R7: square-mode counting element stays even
  p_square_even_r7: assert property (@(posedge clk) disable iff (!rst_n)
    run_q && mode_q == M_SQUARE |-> !ce_q[0]);

  // R12: no enable and no write means nothing moves
  p_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !tick && !mode_wr && !cnt_wr |=> $stable(ce_q) && $stable(out_q));

  // R5: a count write leaves a running one-shot output untouched
  p_oneshot_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr && !mode_wr && mode_q == M_ONESHOT |=> $stable(out_q));

endmodule

// File: rtl/pit_channel.sv
module pit_channel #(
  parameter int DIGITS = 4,
  parameter bit BCD_EN = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cnt_en,
  input  logic                gate,
  input  logic                ctl_wr,
  input  logic [2:0]          ctl_mode,
  input  logic                ctl_bcd,
  input  logic                ld_wr,
  input  logic [4*DIGITS-1:0] ld_val,
  output logic                out_o,
  output logic [4*DIGITS-1:0] count_o,
  output logic                null_o
);

  localparam int W = 4 * DIGITS;

  logic         trig;
  logic         bcd_q;
  logic [W-1:0] ce_q, cr_q, per_q;
  logic [W-1:0] dec1, dec2, hi_val, lo_val;

  pit_gate_edge u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (cnt_en),
    .gate  (gate),
    .rise  (trig)
  );

  pit_step #(.DIGITS(DIGITS), .BCD_EN(BCD_EN)) u_step (
    .cnt    (ce_q),
    .hi_src (cr_q),
    .lo_src (per_q),
    .bcd    (bcd_q),
    .dec1   (dec1),
    .dec2   (dec2),
    .hi_val (hi_val),
    .lo_val (lo_val)
  );

  pit_ctrl #(.W(W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (cnt_en),
    .gate    (gate),
    .trig    (trig),
    .mode_wr (ctl_wr),
    .mode_in (ctl_mode),
    .bcd_in  (ctl_bcd),
    .cnt_wr  (ld_wr),
    .cnt_in  (ld_val),
    .dec1    (dec1),
    .dec2    (dec2),
    .hi_val  (hi_val),
    .lo_val  (lo_val),
    .ce_q    (ce_q),
    .cr_q    (cr_q),
    .per_q   (per_q),
    .bcd_q   (bcd_q),
    .out_q   (out_o),
    .null_q  (null_o)
  );

  assign count_o = ce_q;

endmodule

// File: tb/test_pit_channel.sv
module test_pit_channel;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_en = 1'b1;
  logic        gate = 1'b1;
  logic        ctl_wr = 1'b0;
  logic [2:0]  ctl_mode = 3'd0;
  logic        ctl_bcd = 1'b0;
  logic        ld_wr = 1'b0;
  logic [15:0] ld_val = 16'd0;
  logic        out_o;
  logic [15:0] count_o;
  logic        null_o;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  pit_channel i_pit_channel (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .gate(gate),
    .ctl_wr(ctl_wr), .ctl_mode(ctl_mode), .ctl_bcd(ctl_bcd),
    .ld_wr(ld_wr), .ld_val(ld_val),
    .out_o(out_o), .count_o(count_o), .null_o(null_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_mode(input int m, input bit b);
    ctl_wr = 1'b1; ctl_mode = 3'(m); ctl_bcd = b;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic load(input int v);
    ld_wr = 1'b1; ld_val = 16'(v);
    @(negedge clk);
    ld_wr = 1'b0;
  endtask

  // cycles until out_o changes level
  task automatic wait_change(output int n);
    logic lvl;
    lvl = out_o;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (out_o == lvl && n < 70000);
  endtask

  function automatic int to_bcd(input int v);
    return ((v / 1000) % 10) * 4096 + ((v / 100) % 10) * 256 +
           ((v / 10) % 10) * 16 + (v % 10);
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL R12 watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    step(3);
    rst_n = 1'b1;
    step(1);
    chk("R1 reset out", out_o, 0);
    chk("R1 reset count", count_o, 0);
    chk("R1 reset null", null_o, 1);

    // R4 sweep, binary and BCD
    for (int k = 1; k <= 20; k++) begin
      set_mode(0, 0); load(k); wait_change(n);
      chk("R4 mode0 binary rise", n, k + 1);
      set_mode(0, 1); load(to_bcd(k)); wait_change(n);
      chk("R3 mode0 bcd rise", n, k + 1);
    end
    // R11 flag across transfer
    set_mode(0, 0); load(6);
    chk("R11 null after write", null_o, 1);
    step(1);
    chk("R11 null after transfer", null_o, 0);
    // R10 pause in mode 0
    step(1); gate = 1'b0; step(3);
    chk("R10 mode0 frozen count", count_o, 5);
    gate = 1'b1; wait_change(n);
    chk("R10 mode0 resume", n, 5);
    // R4 mid rewrite
    set_mode(0, 0); load(10); step(4); load(20);
    chk("R4 low after rewrite", out_o, 0);
    wait_change(n);
    chk("R4 rewrite restarts", n, 21);
    // R3 BCD decrement
    set_mode(0, 1); load('h25); step(1);
    chk("R3 bcd loaded", count_o, 'h25);
    step(6);
    chk("R3 bcd borrow", count_o, 'h19);
    wait_change(n);
    chk("R3 bcd remaining", n, 19);
    // R2 / R3 full range
    set_mode(0, 0); load(0); wait_change(n);
    chk("R2 binary zero", n, 65537);
    set_mode(0, 1); load(0); wait_change(n);
    chk("R3 bcd zero", n, 10001);

    // R12 alternating enable
    set_mode(0, 0); load(5);
    n = 0;
    do begin
      cnt_en = (n % 2 == 0);
      @(negedge clk);
      n++;
    end while (!out_o && n < 100);
    cnt_en = 1'b1;
    chk("R12 half-rate enable", n, 11);

    // R5 one-shot
    for (int k = 1; k <= 10; k++) begin
      gate = 1'b0; set_mode(1, 0); load(k); gate = 1'b1;
      wait_change(n); wait_change(n);
      chk("R5 shot width", n, k);
    end
    gate = 1'b0; set_mode(1, 0); load(8);
    step(2);
    chk("R11 null until trigger", null_o, 1);
    chk("R5 idle high", out_o, 1);
    gate = 1'b1; wait_change(n);
    chk("R5 trigger fall", n, 1);
    chk("R11 null cleared by trigger", null_o, 0);
    wait_change(n);
    chk("R5 first shot", n, 8);
    gate = 1'b0; step(1); gate = 1'b1; wait_change(n);
    step(3); load(20); wait_change(n);
    chk("R5 write ignored mid shot", n, 5);
    gate = 1'b0; step(1); gate = 1'b1; wait_change(n);
    wait_change(n);
    chk("R5 retrigger uses new count", n, 20);

    // R6 rate generator
    gate = 1'b1;
    for (int k = 2; k <= 12; k++) begin
      set_mode(2, 0); load(k);
      wait_change(n); chk("R6 first fall", n, k);
      wait_change(n); chk("R6 low width", n, 1);
      wait_change(n); chk("R6 high width", n, k - 1);
    end
    set_mode(2, 0); load(6); wait_change(n); wait_change(n);
    step(2); load(9);
    chk("R11 null pending mid period", null_o, 1);
    wait_change(n); chk("R6 period kept", n, 3);
    wait_change(n);
    chk("R11 null cleared at reload", null_o, 0);
    wait_change(n); chk("R6 new period", n, 8);
    set_mode(2, 0); load(5); wait_change(n); wait_change(n);
    step(1); gate = 1'b0;
    for (int c = 0; c < 4; c++) begin
      step(1); chk("R10 rate out held high", out_o, 1);
    end
    gate = 1'b1; wait_change(n);
    chk("R10 rate resume", n, 3);
    set_mode(6, 0); load(5); wait_change(n);
    chk("R13 code 6 as rate", n, 5);

    // R7 square wave
    for (int k = 2; k <= 21; k++) begin
      set_mode(3, 0); load(k);
      wait_change(n); chk("R7 first high", n, 1 + (k + 1) / 2);
      wait_change(n); chk("R7 low half", n, k / 2);
      wait_change(n); chk("R7 high half", n, (k + 1) / 2);
    end
    set_mode(3, 1); load('h09); wait_change(n); wait_change(n);
    chk("R7 bcd 9 low", n, 4);
    wait_change(n); chk("R7 bcd 9 high", n, 5);
    set_mode(3, 1); load('h15); wait_change(n); wait_change(n);
    chk("R7 bcd 15 low", n, 7);
    wait_change(n); chk("R7 bcd 15 high", n, 8);
    set_mode(3, 1); load(0); wait_change(n);
    chk("R3 bcd zero square high", n, 5001);
    wait_change(n); chk("R3 bcd zero square low", n, 5000);
    set_mode(3, 0); load(8); wait_change(n); wait_change(n);
    step(1); load(12);
    wait_change(n); chk("R7 high kept", n, 3);
    wait_change(n); chk("R7 low uses old period", n, 4);
    wait_change(n); chk("R7 high new period", n, 6);
    wait_change(n); chk("R7 low new period", n, 6);
    set_mode(7, 0); load(6); wait_change(n);
    chk("R13 code 7 as square", n, 4);

    // R8 software strobe
    for (int k = 1; k <= 20; k++) begin
      set_mode(4, 0); load(k);
      wait_change(n); chk("R8 strobe fall", n, k + 1);
      wait_change(n); chk("R8 strobe width", n, 1);
    end
    step(5);
    chk("R8 stays high after strobe", out_o, 1);
    set_mode(4, 0); load(10); step(2); load(6); wait_change(n);
    chk("R8 rewrite restarts", n, 7);

    // R9 hardware strobe
    for (int k = 1; k <= 15; k++) begin
      gate = 1'b0; set_mode(5, 0); load(k); step(2);
      chk("R9 waits for trigger", out_o, 1);
      gate = 1'b1;
      wait_change(n); chk("R9 strobe fall", n, k + 1);
      wait_change(n); chk("R9 strobe width", n, 1);
    end
    gate = 1'b0; set_mode(5, 0); load(10); step(1);
    gate = 1'b1; step(3); gate = 1'b0; step(1); gate = 1'b1;
    wait_change(n);
    chk("R9 retrigger restarts", n, 11);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule